// File: doc/BRIEF.md
# Synchronous NOR Burst Read Sequencer

This block runs one synchronous read burst against an external NOR-type memory. It runs entirely on the fast system clock. It derives the memory clock as an integer division of that clock, and it sequences chip select and the active-low address-valid strobe around the clock. It then captures one data word on each memory clock rising edge once a programmable latency has passed.

A request carries an address, a data size and a beat count. The divider setting, the latency and the memory bus width come in as configuration inputs. All of these are sampled in the cycle the request is accepted, so they may change freely during a burst. The block starts with one clock-free cycle and then holds address-valid low for exactly one memory clock period. The first rising memory clock edge falls near the middle of that pulse. Each sampled word comes back with a one-cycle strobe. A one-cycle done pulse marks the end of the access. After that the memory clock is parked low and chip select is released.

Top module: `snor_burst_seq`

## Requirements
- R1: The memory clock period, in system cycles, is R = max(divider field + 1, width ratio, 2). Size encodings are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits, on both the bus-width and request-size inputs. The width ratio is 4 for a 32-bit bus with an 8-bit request, 2 for a 32-bit bus with a 16-bit request, and 1 otherwise. Configuration is sampled when the request is accepted.
- R2: With divider field 1 and an 8-bit request, the period is 4 cycles on a 32-bit bus and 2 cycles on a 16-bit bus.
- R3: Every memory clock period is low for floor(R/2) system cycles and then high for the remaining cycles.
- R4: In the first cycle after acceptance, chip select is low, address-valid is high and the memory clock is low.
- R5: Address-valid goes low in the second cycle after acceptance and stays low for exactly R cycles. The first memory clock rise comes floor(R/2) cycles after address-valid falls.
- R6: Rising edges are numbered from 1, where edge 1 is the one inside the address-valid pulse. The first word is sampled at edge number latency + 2.
- R7: A beat field n yields n + 1 words on consecutive rising edges. Each word is the value on the data input just before the system edge that raises the memory clock. Its strobe is high for that one cycle only.
- R8: The done output pulses for one cycle at the end of the memory period that held the last sample. In that cycle chip select is high and the clock is low. Chip select stays low for 1 + (latency + n + 2) * R cycles.
- R9: Between accesses, chip select and address-valid are high, the clock is low and ready is high. A request raised while an access is running is ignored.
- R10: The memory address output equals the accepted request address for as long as chip select is low.
- R11: During reset, chip select and address-valid are high, the clock, the sample strobe and done are low, and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken |
| req_addr_i | input | ADDR_W | Burst start address |
| req_size_i | input | 2 | Request data size code |
| req_beats_i | input | BEAT_W | Word count minus one |
| cfg_div_i | input | DIV_W | Clock divider field |
| cfg_lat_i | input | LAT_W | Data latency in memory clocks |
| cfg_bus_w_i | input | 2 | Memory bus width code |
| mem_clk_o | output | 1 | Memory clock |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_data_i | input | DATA_W | Memory read data |
| rd_valid_o | output | 1 | Sample strobe, one cycle per word |
| rd_data_o | output | DATA_W | Sampled word |
| done_o | output | 1 | Access finished pulse |

## Verification
The hardest situation to reach from the ports is a request arriving in the middle of a running burst. It must leave both the address and the timing of the current access untouched. The stimulus reaches it by raising a foreign request, with a different address, in the third cycle of about half of the accesses. Two further cases are also hard to line up: an odd clock ratio, where the two halves of the period differ in length, and a latency that runs to its limit. Both are covered by directed accesses with divider fields 2 and 4 and latency 15, alongside seeded random configurations.

// File: rtl/snor_pkg.sv
`timescale 1ns/1ps
package snor_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2
    } size_code_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/snor_ratio.sv
`timescale 1ns/1ps
module snor_ratio #(
    parameter int DIV_W   = 4,
    parameter int RATIO_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0]   div_i,
    input  logic [1:0]         bus_w_i,
    input  logic [1:0]         req_sz_i,
    output logic [RATIO_W-1:0] ratio_o
);
    import snor_pkg::*;

    logic [RATIO_W-1:0] base;
    logic [RATIO_W-1:0] wide;
    logic [RATIO_W-1:0] pick;

    always_comb begin
        base = {1'b0, div_i} + RATIO_W'(1);
        wide = RATIO_W'(1);
        if (size_code_e'(bus_w_i) == SZ_32) begin
            if (size_code_e'(req_sz_i) == SZ_8)       wide = RATIO_W'(4);
            else if (size_code_e'(req_sz_i) == SZ_16) wide = RATIO_W'(2);
        end
        pick = (base > wide) ? base : wide;
        // a registered clock needs at least two system cycles per period
        ratio_o = (pick < RATIO_W'(2)) ? RATIO_W'(2) : pick;
    end

endmodule

// File: rtl/snor_clkgen.sv
`timescale 1ns/1ps
module snor_clkgen #(
    parameter int RATIO_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               mem_clk_o,
    output logic               rise_o,
    output logic               wrap_o
);

    typedef struct packed {
        logic               run;
        logic [RATIO_W-1:0] phase;
        logic               mclk;
    } cg_t;

    cg_t cg_d, cg_q;
    logic [RATIO_W-1:0] half;
    logic               wrap;

    always_comb begin
        half       = ratio_i >> 1;
        wrap       = cg_q.run && (cg_q.phase == ratio_i - RATIO_W'(1));
        cg_d       = cg_q;
        cg_d.run   = run_i;
        if (cg_q.run) cg_d.phase = wrap ? '0 : cg_q.phase + RATIO_W'(1);
        else          cg_d.phase = '0;
        cg_d.mclk  = run_i && (cg_d.phase >= half);
        rise_o     = cg_q.run && (cg_d.phase == half);
        wrap_o     = wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cg_q <= '0;
        else         cg_q <= cg_d;
    end

    assign mem_clk_o = cg_q.mclk;

endmodule

// File: rtl/snor_ctrl.sv
`timescale 1ns/1ps
module snor_ctrl #(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32,
    parameter int LAT_W   = 4,
    parameter int BEAT_W  = 4,
    parameter int RATIO_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LAT_W-1:0]   lat_i,
    input  logic [BEAT_W-1:0]  beats_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [DATA_W-1:0]  mem_data_i,
    input  logic               rise_i,
    input  logic               wrap_i,
    output logic               req_ready_o,
    output logic               run_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cs_n_o,
    output logic               adv_n_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               rd_valid_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               done_o
);
    import snor_pkg::*;

    localparam int MCYC_W = ((LAT_W > BEAT_W) ? LAT_W : BEAT_W) + 2;
    localparam int WCNT_W = BEAT_W + 1;

    typedef struct packed {
        seq_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [LAT_W-1:0]   lat;
        logic [BEAT_W-1:0]  beats;
        logic [RATIO_W-1:0] ratio;
        logic [MCYC_W-1:0]  mcyc;
        logic [WCNT_W-1:0]  wcnt;
        logic [DATA_W-1:0]  data;
        logic               samp;
        logic               done;
        logic               cs_n;
        logic               adv_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [WCNT_W-1:0] total;
    logic              lat_over;

    always_comb begin
        total      = {1'b0, ctl_q.beats} + WCNT_W'(1);
        lat_over   = ctl_q.mcyc > MCYC_W'(ctl_q.lat);
        ctl_d      = ctl_q;
        ctl_d.samp = 1'b0;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            SEQ_IDLE: begin
                if (req_valid_i) begin
                    ctl_d.st    = SEQ_LEAD;
                    ctl_d.addr  = addr_i;
                    ctl_d.lat   = lat_i;
                    ctl_d.beats = beats_i;
                    ctl_d.ratio = ratio_i;
                    ctl_d.mcyc  = '0;
                    ctl_d.wcnt  = '0;
                end
            end
            SEQ_LEAD: begin
                ctl_d.st = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (rise_i && lat_over && (ctl_q.wcnt != total)) begin
                    ctl_d.data = mem_data_i;
                    ctl_d.samp = 1'b1;
                    ctl_d.wcnt = ctl_q.wcnt + WCNT_W'(1);
                end
                if (wrap_i) begin
                    if (ctl_q.wcnt == total) begin
                        ctl_d.st   = SEQ_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.mcyc = ctl_q.mcyc + MCYC_W'(1);
                    end
                end
            end
            default: ctl_d.st = SEQ_IDLE;
        endcase
        ctl_d.cs_n  = (ctl_d.st == SEQ_IDLE);
        ctl_d.adv_n = !((ctl_d.st == SEQ_RUN) && (ctl_d.mcyc == '0));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q       <= '0;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.adv_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o = (ctl_q.st == SEQ_IDLE);
    assign run_o       = (ctl_d.st == SEQ_RUN);
    assign ratio_o     = ctl_q.ratio;
    assign cs_n_o      = ctl_q.cs_n;
    assign adv_n_o     = ctl_q.adv_n;
    assign addr_o      = ctl_q.addr;
    assign rd_valid_o  = ctl_q.samp;
    assign rd_data_o   = ctl_q.data;
    assign done_o      = ctl_q.done;

endmodule

// File: rtl/snor_burst_seq.sv
`timescale 1ns/1ps
module snor_burst_seq #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 4,
    parameter int LAT_W  = 4,
    parameter int BEAT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [BEAT_W-1:0] req_beats_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [LAT_W-1:0]  cfg_lat_i,
    input  logic [1:0]        cfg_bus_w_i,
    output logic              mem_clk_o,
    output logic              mem_cs_n_o,
    output logic              mem_adv_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);

    localparam int RATIO_W = DIV_W + 1;

    logic [RATIO_W-1:0] ratio_new;
    logic [RATIO_W-1:0] ratio_held;
    logic               run;
    logic               rise;
    logic               wrap;

    snor_ratio #(
        .DIV_W   (DIV_W),
        .RATIO_W (RATIO_W)
    ) u_ratio (
        .div_i    (cfg_div_i),
        .bus_w_i  (cfg_bus_w_i),
        .req_sz_i (req_size_i),
        .ratio_o  (ratio_new)
    );

    snor_clkgen #(
        .RATIO_W (RATIO_W)
    ) u_clkgen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .ratio_i   (ratio_held),
        .mem_clk_o (mem_clk_o),
        .rise_o    (rise),
        .wrap_o    (wrap)
    );

    snor_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LAT_W   (LAT_W),
        .BEAT_W  (BEAT_W),
        .RATIO_W (RATIO_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .addr_i      (req_addr_i),
        .lat_i       (cfg_lat_i),
        .beats_i     (req_beats_i),
        .ratio_i     (ratio_new),
        .mem_data_i  (mem_data_i),
        .rise_i      (rise),
        .wrap_i      (wrap),
        .req_ready_o (req_ready_o),
        .run_o       (run),
        .ratio_o     (ratio_held),
        .cs_n_o      (mem_cs_n_o),
        .adv_n_o     (mem_adv_n_o),
        .addr_o      (mem_addr_o),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/snor_burst_seq_chk.sv
`timescale 1ns/1ps
module snor_burst_seq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_ready_o,
    input logic              mem_clk_o,
    input logic              mem_cs_n_o,
    input logic              mem_adv_n_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              rd_valid_o,
    input logic              done_o
);

    p_lead_clock_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_cs_n_o) |-> (!mem_clk_o && mem_adv_n_o));

    p_adv_after_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_cs_n_o) |=> !mem_adv_n_o);

    p_adv_inside_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_adv_n_o |-> !mem_cs_n_o);

    p_sample_on_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $rose(mem_clk_o));

    p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (mem_cs_n_o && !mem_clk_o && $past(!mem_cs_n_o)));

    p_clk_parked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_cs_n_o |-> !mem_clk_o);

    p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (mem_cs_n_o && mem_adv_n_o));

    p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

endmodule

bind snor_burst_seq snor_burst_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ready_o (req_ready_o),
    .mem_clk_o   (mem_clk_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_adv_n_o (mem_adv_n_o),
    .mem_addr_o  (mem_addr_o),
    .rd_valid_o  (rd_valid_o),
    .done_o      (done_o)
);

// File: tb/snor_burst_seq_bench.sv
`timescale 1ns/1ps
module snor_burst_seq_bench;

    localparam int ADDR_W = 26;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 4;
    localparam int LAT_W  = 4;
    localparam int BEAT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic [DIV_W-1:0]  cfg_div = '0;
    logic [LAT_W-1:0]  cfg_lat = '0;
    logic [1:0]        cfg_bus_w = '0;
    logic              mem_clk, mem_cs_n, mem_adv_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    snor_burst_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DIV_W (DIV_W),
        .LAT_W (LAT_W), .BEAT_W (BEAT_W)
    ) u_snor_burst_seq (
        .clk_i (clk), .rst_ni (rst_n),
        .req_valid_i (req_valid), .req_ready_o (req_ready),
        .req_addr_i (req_addr), .req_size_i (req_size), .req_beats_i (req_beats),
        .cfg_div_i (cfg_div), .cfg_lat_i (cfg_lat), .cfg_bus_w_i (cfg_bus_w),
        .mem_clk_o (mem_clk), .mem_cs_n_o (mem_cs_n), .mem_adv_n_o (mem_adv_n),
        .mem_addr_o (mem_addr), .mem_data_i (mem_data),
        .rd_valid_o (rd_valid), .rd_data_o (rd_data), .done_o (done)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ratio(int div, int bw, int rs);
        int r = div + 1;
        int w = 1;
        if (bw == 2 && rs == 0) w = 4;
        else if (bw == 2 && rs == 1) w = 2;
        if (w > r) r = w;
        if (r < 2) r = 2;
        return r;
    endfunction

    task automatic run_access(int div, int bw, int rs, int lat, int beats, bit poke, string rtag);
        int r = exp_ratio(div, bw, rs);
        int lo = r / 2;
        int exp_cs = 1 + (lat + beats + 2) * r;
        int cyc = 0, cs_low = 0, adv_low = 0, adv_first = -1;
        int rise_idx = 0, first_rise = -1, last_rise = -1, period1 = -1;
        int per_bad = 0, hi_bad = 0, hi_run = 0, words = 0, first_word = -1;
        int data_bad = 0, addr_bad = 0, done_cyc = -1, lead_code = -1, end_code = -1;
        bit prev_clk = 1'b0;
        bit is_rise;
        logic [ADDR_W-1:0] a = ADDR_W'($urandom);
        logic [DATA_W-1:0] drv = '0;

        @(negedge clk);
        chk("R9", "ready before request", req_ready, 1);
        req_addr = a; cfg_div = DIV_W'(div); cfg_bus_w = 2'(bw); req_size = 2'(rs);
        cfg_lat = LAT_W'(lat); req_beats = BEAT_W'(beats); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // scramble configuration after acceptance: it must have been captured
        cfg_div = DIV_W'($urandom); cfg_lat = LAT_W'($urandom); req_beats = BEAT_W'($urandom);
        while (done_cyc < 0 && cyc < 3000) begin
            cyc++;
            is_rise = mem_clk && !prev_clk;
            if (cyc == 1) lead_code = {mem_cs_n, mem_adv_n, mem_clk};
            if (!mem_cs_n) begin
                cs_low++;
                if (mem_addr != a) addr_bad++;
            end
            if (!mem_adv_n) begin
                adv_low++;
                if (adv_first < 0) adv_first = cyc;
            end
            if (mem_clk) hi_run++;
            if (!mem_clk && prev_clk) begin
                if (hi_run != r - lo) hi_bad++;
                hi_run = 0;
            end
            if (is_rise) begin
                rise_idx++;
                if (first_rise < 0) first_rise = cyc;
                else begin
                    if (period1 < 0) period1 = cyc - last_rise;
                    if (cyc - last_rise != r) per_bad++;
                end
                last_rise = cyc;
            end
            if (rd_valid) begin
                words++;
                if (first_word < 0) first_word = rise_idx;
                if (!is_rise || rise_idx != lat + 1 + words || rd_data != drv) data_bad++;
            end
            if (done) begin
                done_cyc = cyc;
                end_code = {mem_cs_n, mem_clk, req_ready};
            end
            prev_clk = mem_clk;
            if (poke && cyc == 3) begin
                req_addr = ~a; req_valid = 1'b1;
            end
            if (poke && cyc == 4) req_valid = 1'b0;
            drv = DATA_W'($urandom);
            mem_data = drv;
            @(negedge clk);
        end
        chk(rtag, "period of first two rises", period1, r);
        chk("R3", "period violations", per_bad, 0);
        chk("R3", "high phase violations", hi_bad, 0);
        chk("R4", "lead cycle {cs,adv,clk}", lead_code, 3'b010);
        chk("R5", "address-valid fall cycle", adv_first, 2);
        chk("R5", "address-valid low length", adv_low, r);
        chk("R5", "first clock rise cycle", first_rise, 2 + lo);
        chk("R6", "edge index of first word", first_word, lat + 2);
        chk("R7", "word count", words, beats + 1);
        chk("R7", "sample timing or data errors", data_bad, 0);
        chk("R8", "done cycle", done_cyc, exp_cs + 1);
        chk("R8", "chip select low cycles", cs_low, exp_cs);
        chk("R8", "done cycle {cs,clk,ready}", end_code, 3'b101);
        chk("R10", "address mismatches", addr_bad, 0);
        if (poke) chk("R9", "address disturbed by busy request", addr_bad, 0);
        @(negedge clk);
        chk("R9", "idle {cs,adv,clk,ready}", {mem_cs_n, mem_adv_n, mem_clk, req_ready}, 4'b1101);
    endtask

    initial begin
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(negedge clk);
        chk("R11", "reset {cs,adv,clk,ready,valid,done}",
            {mem_cs_n, mem_adv_n, mem_clk, req_ready, rd_valid, done}, 6'b110100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        run_access(1, 2, 0, 0, 0, 1'b0, "R2");   // quarter rate
        run_access(1, 1, 0, 1, 2, 1'b0, "R2");   // half rate
        run_access(0, 0, 0, 0, 0, 1'b0, "R1");   // floor of two
        run_access(0, 2, 1, 2, 1, 1'b1, "R1");   // width ratio two
        run_access(2, 2, 2, 0, 3, 1'b1, "R1");   // odd ratio three
        run_access(4, 2, 0, 15, 15, 1'b1, "R1"); // odd five, longest latency
        run_access(15, 0, 2, 3, 0, 1'b0, "R1");  // largest divider
        for (int i = 0; i < 30; i++) begin
            run_access(int'($urandom_range(0, 15)), int'($urandom_range(0, 2)),
                       int'($urandom_range(0, 2)), int'($urandom_range(0, 15)),
                       int'($urandom_range(0, 15)), 1'($urandom), "R1");
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule